// File: doc/BRIEF.md
# Deferred Stored-CRC Repair Unit

This block keeps the stored CRC-16 word of the identifier bank honest without recomputing it on every write. It watches word writes into the identifier bank. When a write lands on the protocol-control word (word 1) or on any identifier word (words 0x02 to 0x20), the stored CRC at word 0 is flagged stale. Writes to word 0 itself, to the two extended protocol-control words at 0x21 and 0x22, and to other banks leave the flag alone.

The repair is lazy. When the tag backscatters an acknowledge response, the transmitter streams the words it sends into this block: the protocol-control word first, then the identifier words. The block runs a CRC-16 over them and presents the result so the transmitter can append it. If the response goes out in full and untruncated while the stored CRC is stale, the block writes the computed value back into word 0 and clears the flag. A truncated response carries the old stored value unchanged, so it repairs nothing. An identifier-bank write that arrives while a response is in progress cancels that response's write-back.

The control is one state machine. It has six states. IDLE waits for a response. GET_PC takes the protocol-control word. BODY counts identifier words. TAIL holds the finished CRC until the response ends. SKIP follows a truncated response. COMMIT drives the one-cycle write to word 0. Its transitions are as follows. START enters GET_PC, or SKIP when truncated, from any state. PC_LAST goes GET_PC to TAIL for a zero length, and PC_MORE goes GET_PC to BODY. BODY_LAST goes BODY to TAIL on the final word. REPAIR goes TAIL to COMMIT on a completed response that must write back. FINISH goes TAIL to IDLE on any other completion. CUT goes to IDLE from GET_PC, BODY, TAIL or SKIP on abort or on an early done. RETIRE goes COMMIT to IDLE.

Top module: `crc_defer_unit`

## Requirements
- R1: After reset, `crc_stale`, `calc_ready` and `crc_wr_en` are all 0.
- R2: A write with `wr_bank_id`=1 to an address from 0x01 to 0x20 sets `crc_stale` in the following cycle. A write to address 0x00, 0x21 or 0x22, or a write with `wr_bank_id`=0, leaves `crc_stale` unchanged.
- R3: For an untruncated response, the CRC is computed as follows. The polynomial is 0x1021, the preset is 0xFFFF, the bits are taken MSB first, and the result is ones-complemented. The input is the first streamed word (protocol-control) followed by N identifier words, where N = bits [15:11] of that first word. From the cycle after the last counted word until the response ends, `calc_ready` is 1 and `calc_crc` holds that value, stable.
- R4: If `rsp_done` arrives in TAIL while `crc_stale`=1 and no cancel applies, `crc_wr_en` pulses in the next cycle with `crc_wr_data` equal to the computed CRC. `crc_stale` is 0 from the cycle after that pulse.
- R5: When `crc_stale`=0, a completed response performs no write.
- R6: A response started with `rsp_trunc`=1 never raises `calc_ready` or `crc_wr_en` and leaves `crc_stale` unchanged.
- R7: Any write with `wr_bank_id`=1 from the `rsp_start` cycle through the `rsp_done` cycle cancels that response's write-back, and `crc_stale` stays 1.
- R8: `rsp_abort`, or `rsp_done` before all N identifier words have been streamed, ends the response with no write.
- R9: If a marking write (as in R2) arrives in the same cycle as the write-back pulse, `crc_stale` stays 1.
- R10: `crc_wr_en` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Memory word write observed |
| wr_bank_id | input | 1 | 1 when the write targets the identifier bank |
| wr_addr | input | 6 | Word address of the observed write |
| rsp_start | input | 1 | Acknowledge response begins |
| rsp_trunc | input | 1 | With `rsp_start`: response is truncated |
| rsp_word_valid | input | 1 | A response word is being sent |
| rsp_word | input | 16 | Response word |
| rsp_done | input | 1 | Response has been fully sent |
| rsp_abort | input | 1 | Response was cut off |
| calc_ready | output | 1 | `calc_crc` is complete |
| calc_crc | output | 16 | CRC computed over the response |
| crc_wr_en | output | 1 | Write pulse to identifier word 0 |
| crc_wr_data | output | 16 | Value written to word 0 |
| crc_stale | output | 1 | Stored CRC is out of date |

## Verification
Some properties are checked on every cycle. Marking writes set the stale flag. A write-back happens only while the flag is set, only as a single-cycle pulse, and never after an abort or a cancelling write. A truncated response keeps `calc_ready` and the write port quiet, and the computed CRC stays stable while it is offered. Other behaviour needs the bench's scenarios. These include the CRC value over several lengths, including zero and the maximum of 31 identifier words, and the exact cycle and data of each repair. They also include early completion, a write coinciding with the repair pulse, and the insensitivity to words 0x00, 0x21 and 0x22.

// File: rtl/crc_defer_pkg.sv
package crc_defer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_PC,
        ST_BODY,
        ST_TAIL,
        ST_SKIP,
        ST_COMMIT
    } resp_state_t;
endpackage

// File: rtl/crc16_word.sv
module crc16_word #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] chain [0:W];

    assign chain[0] = crc_in;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic fb;
            assign fb = chain[b][W-1] ^ data_in[W-1-b];
            assign chain[b+1] = {chain[b][W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign crc_out = chain[W];
endmodule

// File: rtl/crc_stale_tracker.sv
module crc_stale_tracker #(
    parameter int ADDR_W     = 6,
    parameter int FIRST_MARK = 1,
    parameter int LAST_MARK  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              busy,
    input  logic              rsp_start,
    input  logic              commit,
    output logic              stale,
    output logic              cancel
);
    logic id_wr;
    logic mark;
    logic stale_q;
    logic cancel_q;

    assign id_wr = wr_en && wr_bank_id;
    assign mark  = id_wr && (wr_addr >= ADDR_W'(FIRST_MARK))
                         && (wr_addr <= ADDR_W'(LAST_MARK));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q <= 1'b0;
        end else if (mark) begin
            stale_q <= 1'b1;
        end else if (commit) begin
            stale_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cancel_q <= 1'b0;
        end else if (rsp_start) begin
            cancel_q <= id_wr;
        end else if (busy && id_wr) begin
            cancel_q <= 1'b1;
        end
    end

    assign stale  = stale_q;
    assign cancel = cancel_q || (busy && id_wr);
endmodule

// File: rtl/crc_resp_fsm.sv
module crc_resp_fsm
    import crc_defer_pkg::*;
#(
    parameter int              WORD_W = 16,
    parameter int              LEN_W  = 5,
    parameter logic [WORD_W-1:0] POLY   = 16'h1021,
    parameter logic [WORD_W-1:0] PRESET = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_start,
    input  logic              rsp_trunc,
    input  logic              rsp_word_valid,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_done,
    input  logic              rsp_abort,
    input  logic              stale,
    input  logic              cancel,
    output logic              busy,
    output logic              calc_ready,
    output logic [WORD_W-1:0] calc_crc,
    output logic              crc_wr_en,
    output logic [WORD_W-1:0] crc_wr_data
);
    localparam int LEN_LSB = WORD_W - LEN_W;

    resp_state_t state_q, state_d;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] crc_step;
    logic [LEN_W-1:0]  pc_len;
    logic              take_word;
    logic              ended;

    crc16_word #(.W(WORD_W), .POLY(POLY)) i_step (
        .crc_in  (crc_q),
        .data_in (rsp_word),
        .crc_out (crc_step)
    );

    assign pc_len    = rsp_word[WORD_W-1:LEN_LSB];
    assign take_word = rsp_word_valid && ((state_q == ST_GET_PC) || (state_q == ST_BODY));
    assign ended     = rsp_done || rsp_abort;

    always_comb begin
        state_d = state_q;
        if (rsp_start) begin
            state_d = rsp_trunc ? ST_SKIP : ST_GET_PC;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_GET_PC: begin
                    if (ended)               state_d = ST_IDLE;
                    else if (rsp_word_valid) state_d = (pc_len == '0) ? ST_TAIL : ST_BODY;
                end
                ST_BODY: begin
                    if (ended)                                  state_d = ST_IDLE;
                    else if (rsp_word_valid && left_q == LEN_W'(1)) state_d = ST_TAIL;
                end
                ST_TAIL: begin
                    if (rsp_abort)                         state_d = ST_IDLE;
                    else if (rsp_done && stale && !cancel) state_d = ST_COMMIT;
                    else if (rsp_done)                     state_d = ST_IDLE;
                end
                ST_SKIP:   if (ended) state_d = ST_IDLE;
                ST_COMMIT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= PRESET;
            left_q <= '0;
        end else if (rsp_start) begin
            crc_q  <= PRESET;
            left_q <= '0;
        end else if (take_word) begin
            crc_q <= crc_step;
            if (state_q == ST_GET_PC) left_q <= pc_len;
            else                      left_q <= left_q - LEN_W'(1);
        end
    end

    always_comb begin
        busy       = 1'b0;
        calc_ready = 1'b0;
        crc_wr_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_GET_PC: busy = 1'b1;
            ST_BODY:   busy = 1'b1;
            ST_TAIL: begin
                busy       = 1'b1;
                calc_ready = 1'b1;
            end
            ST_SKIP:   busy = 1'b1;
            ST_COMMIT: begin
                calc_ready = 1'b1;
                crc_wr_en  = 1'b1;
            end
            default: ;
        endcase
    end

    assign calc_crc    = ~crc_q;
    assign crc_wr_data = ~crc_q;
endmodule

// File: rtl/crc_defer_unit.sv
module crc_defer_unit #(
    parameter int WORD_W     = 16,
    parameter int ADDR_W     = 6,
    parameter int LEN_W      = 5,
    parameter int FIRST_MARK = 1,
    parameter int LAST_MARK  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rsp_start,
    input  logic              rsp_trunc,
    input  logic              rsp_word_valid,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_done,
    input  logic              rsp_abort,
    output logic              calc_ready,
    output logic [WORD_W-1:0] calc_crc,
    output logic              crc_wr_en,
    output logic [WORD_W-1:0] crc_wr_data,
    output logic              crc_stale
);
    logic busy;
    logic cancel;

    crc_stale_tracker #(
        .ADDR_W(ADDR_W), .FIRST_MARK(FIRST_MARK), .LAST_MARK(LAST_MARK)
    ) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bank_id (wr_bank_id),
        .wr_addr    (wr_addr),
        .busy       (busy),
        .rsp_start  (rsp_start),
        .commit     (crc_wr_en),
        .stale      (crc_stale),
        .cancel     (cancel)
    );

    crc_resp_fsm #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rsp_start      (rsp_start),
        .rsp_trunc      (rsp_trunc),
        .rsp_word_valid (rsp_word_valid),
        .rsp_word       (rsp_word),
        .rsp_done       (rsp_done),
        .rsp_abort      (rsp_abort),
        .stale          (crc_stale),
        .cancel         (cancel),
        .busy           (busy),
        .calc_ready     (calc_ready),
        .calc_crc       (calc_crc),
        .crc_wr_en      (crc_wr_en),
        .crc_wr_data    (crc_wr_data)
    );
endmodule

// File: rtl/crc_defer_checker.sv
module crc_defer_checker #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_bank_id,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rsp_start,
    input logic              rsp_trunc,
    input logic              rsp_done,
    input logic              rsp_abort,
    input logic              calc_ready,
    input logic [WORD_W-1:0] calc_crc,
    input logic              crc_wr_en,
    input logic              crc_stale
);
    logic mark;
    logic id_wr;
    logic open_q;
    logic cut_q;
    logic trunc_q;

    assign id_wr = wr_en && wr_bank_id;
    assign mark  = id_wr && (wr_addr >= ADDR_W'(1)) && (wr_addr <= ADDR_W'(32));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            cut_q   <= 1'b0;
            trunc_q <= 1'b0;
        end else begin
            if (rsp_start) begin
                open_q  <= 1'b1;
                cut_q   <= id_wr;
                trunc_q <= rsp_trunc;
            end else begin
                if (open_q && id_wr)           cut_q  <= 1'b1;
                if (rsp_done || rsp_abort)     open_q <= 1'b0;
            end
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!crc_stale && !crc_wr_en && !calc_ready));

    a_r2_mark_sets_stale: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> crc_stale);

    a_r3_crc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_ready && $past(calc_ready) && !$past(rsp_start)) |-> $stable(calc_crc));

    a_r4_clear_after_repair: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_wr_en && !mark) |=> !crc_stale);

    a_r5_write_only_if_stale: assert property (@(posedge clk) disable iff (!rst_n)
        crc_wr_en |-> crc_stale);

    a_r6_trunc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_q |-> (!calc_ready && !crc_wr_en));

    a_r7_cancel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        crc_wr_en |-> !cut_q);

    a_r8_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_abort && !rsp_start) |=> !crc_wr_en);

    a_r9_mark_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_wr_en && mark) |=> crc_stale);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        crc_wr_en |=> !crc_wr_en);
endmodule

bind crc_defer_unit crc_defer_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_bank_id (wr_bank_id),
    .wr_addr    (wr_addr),
    .rsp_start  (rsp_start),
    .rsp_trunc  (rsp_trunc),
    .rsp_done   (rsp_done),
    .rsp_abort  (rsp_abort),
    .calc_ready (calc_ready),
    .calc_crc   (calc_crc),
    .crc_wr_en  (crc_wr_en),
    .crc_stale  (crc_stale)
);

// File: tb/test_crc_defer_unit.sv
module test_crc_defer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank_id = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic        rsp_start = 1'b0;
    logic        rsp_trunc = 1'b0;
    logic        rsp_word_valid = 1'b0;
    logic [15:0] rsp_word = '0;
    logic        rsp_done = 1'b0;
    logic        rsp_abort = 1'b0;
    logic        calc_ready;
    logic [15:0] calc_crc;
    logic        crc_wr_en;
    logic [15:0] crc_wr_data;
    logic        crc_stale;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    logic        prev_wr = 1'b0;

    always #5 clk = ~clk;

    crc_defer_unit i_crc_defer_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank_id(wr_bank_id),
        .wr_addr(wr_addr), .rsp_start(rsp_start), .rsp_trunc(rsp_trunc),
        .rsp_word_valid(rsp_word_valid), .rsp_word(rsp_word), .rsp_done(rsp_done),
        .rsp_abort(rsp_abort), .calc_ready(calc_ready), .calc_crc(calc_crc),
        .crc_wr_en(crc_wr_en), .crc_wr_data(crc_wr_data), .crc_stale(crc_stale)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_model(input logic [15:0] pc, input int seed);
        logic [15:0] c = 16'hFFFF;
        int n = int'(pc[15:11]);
        for (int i = 0; i <= n; i++) begin
            logic [15:0] w = (i == 0) ? pc : gen_word(seed, i - 1);
            for (int b = 15; b >= 0; b--) begin
                logic fb = c[15] ^ w[b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return ~c;
    endfunction

    function automatic logic [15:0] gen_word(input int seed, input int i);
        return 16'(seed * 16'h1357 + i * 16'h0F1D) ^ 16'hA5C3;
    endfunction

    // monitor: pops expected write-back values as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (crc_wr_en) begin
                if (prev_wr) chk("R10 double pulse", 1, 0);
                if (exp_q.size() == 0) begin
                    chk("R5/R7/R8 unexpected write", 1, 0);
                end else begin
                    chk("R4 write data", {16'h0, crc_wr_data}, {16'h0, exp_q.pop_front()});
                end
            end
            prev_wr <= crc_wr_en;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic poke(input logic bank, input logic [5:0] addr);
        @(negedge clk);
        wr_en = 1'b1; wr_bank_id = bank; wr_addr = addr;
        @(negedge clk);
        wr_en = 1'b0; wr_bank_id = 1'b0;
    endtask

    // mode: 0 full, 1 early done, 2 abort in tail, 3 id write mid, 4 mark at commit
    task automatic send_resp(input logic [15:0] pc, input int seed, input logic trunc,
                             input int mode, input logic expect_wr, input string req);
        int n = int'(pc[15:11]);
        logic [15:0] exp_crc = crc_model(pc, seed);
        @(negedge clk);
        rsp_start = 1'b1; rsp_trunc = trunc;
        @(negedge clk);
        rsp_start = 1'b0; rsp_trunc = 1'b0;
        rsp_word_valid = 1'b1; rsp_word = pc;
        if (trunc) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk({req, " R6 calc_ready"}, {31'h0, calc_ready}, 0);
                rsp_word = gen_word(seed, i);
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                rsp_word = gen_word(seed, i);
                wr_en = (mode == 3 && i == 0); wr_bank_id = (mode == 3 && i == 0);
                wr_addr = 6'h03;
                if (mode == 1 && i == n / 2) break;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; wr_bank_id = 1'b0;
        rsp_word_valid = 1'b0;
        if (!trunc && mode != 1) begin
            chk({req, " R3 calc_ready"}, {31'h0, calc_ready}, 1);
            chk({req, " R3 calc_crc"}, {16'h0, calc_crc}, {16'h0, exp_crc});
        end
        if (expect_wr) exp_q.push_back(exp_crc);
        if (mode == 2) rsp_abort = 1'b1;
        else           rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0; rsp_abort = 1'b0;
        if (mode == 4) begin
            wr_en = 1'b1; wr_bank_id = 1'b1; wr_addr = 6'h01;
        end
        @(negedge clk);
        wr_en = 1'b0; wr_bank_id = 1'b0;
        idle(2);
        chk({req, " queue drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 stale", {31'h0, crc_stale}, 0);
        chk("R1 ready", {31'h0, calc_ready}, 0);
        chk("R1 wr_en", {31'h0, crc_wr_en}, 0);
        rst_n = 1'b1;
        idle(2);

        send_resp({5'd2, 11'h000}, 1, 1'b0, 0, 1'b0, "R5 valid no write");
        chk("R5 stale", {31'h0, crc_stale}, 0);

        poke(1'b1, 6'h00); chk("R2 addr 00 ignored", {31'h0, crc_stale}, 0);
        poke(1'b1, 6'h21); chk("R2 addr 21 ignored", {31'h0, crc_stale}, 0);
        poke(1'b1, 6'h22); chk("R2 addr 22 ignored", {31'h0, crc_stale}, 0);
        poke(1'b0, 6'h05); chk("R2 other bank ignored", {31'h0, crc_stale}, 0);
        poke(1'b1, 6'h01); chk("R2 pc word marks", {31'h0, crc_stale}, 1);

        send_resp({5'd6, 11'h123}, 2, 1'b1, 0, 1'b0, "R6 truncated");
        chk("R6 stale kept", {31'h0, crc_stale}, 1);

        send_resp({5'd6, 11'h123}, 3, 1'b0, 0, 1'b1, "R4 repair");
        chk("R4 stale cleared", {31'h0, crc_stale}, 0);

        poke(1'b1, 6'h20); chk("R2 last id word marks", {31'h0, crc_stale}, 1);
        send_resp({5'd4, 11'h0AA}, 4, 1'b0, 3, 1'b0, "R7 cancel");
        chk("R7 stale kept", {31'h0, crc_stale}, 1);

        send_resp({5'd8, 11'h055}, 5, 1'b0, 1, 1'b0, "R8 early done");
        chk("R8 early stale kept", {31'h0, crc_stale}, 1);
        send_resp({5'd3, 11'h7FF}, 6, 1'b0, 2, 1'b0, "R8 abort");
        chk("R8 abort stale kept", {31'h0, crc_stale}, 1);

        send_resp({5'd0, 11'h300}, 7, 1'b0, 0, 1'b1, "R3 zero length");
        chk("R4 stale cleared len0", {31'h0, crc_stale}, 0);

        poke(1'b1, 6'h10);
        send_resp({5'd31, 11'h001}, 8, 1'b0, 4, 1'b1, "R9 mark at commit");
        chk("R9 stale kept", {31'h0, crc_stale}, 1);

        send_resp({5'd31, 11'h001}, 9, 1'b0, 0, 1'b1, "R3 max length");
        chk("R4 stale cleared len31", {31'h0, crc_stale}, 0);

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        chk("watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule